// File: doc/BRIEF.md
# Little-Endian Load/Store Unit with Access Fault

This block sits between a core's execute stage and a word-organized data memory. For each request it forms the effective address from a base register and a signed 16-bit displacement. It decodes the access width and signedness from the opcode. It then drives the memory port: a word address, one write enable per byte lane, and write data already steered into the lanes.

Loads read a whole word. One cycle later the unit picks the addressed byte or halfword out of that word in little-endian order. It then extends the value to 32 bits, either with its sign or with zeros.

Two kinds of address raise a combinational fault flag in the request cycle and suppress every memory operation:

- An address that breaks the alignment rule for its width.
- An address outside the legal window. The window starts at 1 and ends just below the configured memory size.

Requests whose opcode is not a load or store pass through without an access and without a fault.

Top module: `lsu_le`

## Requirements
- R1: The effective address is `base + sign_extend(offset)` in 32-bit wrap-around arithmetic. `mem_addr` carries that address divided by four (bits AW-1:2).
- R2: A legal load raises `mem_re` in the request cycle. `load_valid` is high in the following cycle exactly when `mem_re` was high in the request cycle. The load encodings are: byte signed 0x20, halfword signed 0x21, word 0x23, byte unsigned 0x24, halfword unsigned 0x25.
- R3: Load results are taken little-endian: the byte at address offset k within a word is `mem_rdata[8k+7:8k]`. A halfword at offset 0 is bits 15:0 and at offset 2 is bits 31:16. Opcodes 0x20 and 0x21 sign-extend the result; 0x24 and 0x25 zero-extend it.
- R4: Store encodings are byte 0x28, halfword 0x29, word 0x2b. A legal byte store drives `mem_we = 1 << ea[1:0]`. A halfword store drives 4'b0011 when ea[1] is 0 and 4'b1100 when it is 1. A word store drives 4'b1111.
- R5: Store data is replicated across lanes: `{4{d[7:0]}}` for bytes, `{2{d[15:0]}}` for halfwords, and `d` unchanged for words.
- R6: A halfword access with ea[0]=1 raises `fault`, as does a word access with ea[1:0]≠0. Byte accesses are never misaligned.
- R7: An access at ea=0 or at ea ≥ MEM_BYTES raises `fault`.
- R8: While `fault` is high, `mem_we` is 0 and `mem_re` is 0, and `load_valid` stays low in the next cycle.
- R9: A request with any other opcode, or with `req_valid` low, produces no fault, no read and no write.
- R10: While `rst_n` is low, `load_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| opcode | input | 6 | Instruction major opcode |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to store |
| mem_addr | output | AW-2 | Word address to memory |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, valid one cycle after `mem_re` |
| fault | output | 1 | Misaligned or out-of-range access |
| load_valid | output | 1 | `load_data` is valid this cycle |
| load_data | output | 32 | Extended load result |

## Verification
The bench builds the unit with MEM_BYTES set to 1024, so the memory model is a 256-word array. At that size, both the last legal word (0x3FC) and the first illegal address (0x400) are easy to reach with ordinary base values. Negative displacements, address 0 from a wrapped sum, and address 1 are all exercised. Every lane of a stored word is then read back with each load width and each extension mode.

// File: rtl/lsu_le.sv
module lsu_le #(
  parameter int unsigned MEM_BYTES = 65536,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [5:0]    opcode,
  input  logic [31:0]   base,
  input  logic [15:0]   offset,
  input  logic [31:0]   store_data,
  output logic [AW-3:0] mem_addr,
  output logic          mem_re,
  output logic [3:0]    mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          fault,
  output logic          load_valid,
  output logic [31:0]   load_data
);
  localparam logic [5:0] OP_LB = 6'h20, OP_LH = 6'h21, OP_LW = 6'h23,
                         OP_LBU = 6'h24, OP_LHU = 6'h25,
                         OP_SB = 6'h28, OP_SH = 6'h29, OP_SW = 6'h2b;
  localparam logic [31:0] LIMIT = 32'(MEM_BYTES);

  logic [31:0] ea;
  logic        is_ld, is_st, is_half, is_word, misal, oob;
  logic [3:0]  lanes;

  assign ea = base + {{16{offset[15]}}, offset};

  assign is_ld = req_valid && (opcode == OP_LB || opcode == OP_LH || opcode == OP_LW ||
                               opcode == OP_LBU || opcode == OP_LHU);
  assign is_st = req_valid && (opcode == OP_SB || opcode == OP_SH || opcode == OP_SW);

  assign is_half = opcode[1:0] == 2'b01;
  assign is_word = opcode[1:0] == 2'b11;

  assign misal = (is_half && ea[0]) || (is_word && ea[1:0] != 2'b00);
  assign oob   = (ea == 32'd0) || (ea >= LIMIT);
  assign fault = (is_ld || is_st) && (misal || oob);

  always_comb begin
    if (is_word)      lanes = 4'b1111;
    else if (is_half) lanes = ea[1] ? 4'b1100 : 4'b0011;
    else              lanes = 4'b0001 << ea[1:0];
  end

  assign mem_addr  = ea[AW-1:2];
  assign mem_re    = is_ld && !fault;
  assign mem_we    = (is_st && !fault) ? lanes : 4'b0000;
  assign mem_wdata = is_word ? store_data :
                     is_half ? {2{store_data[15:0]}} : {4{store_data[7:0]}};

  logic [1:0] r_lane;
  logic       r_half, r_word, r_uns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      r_lane <= 2'b00;
      r_half <= 1'b0;
      r_word <= 1'b0;
      r_uns  <= 1'b0;
    end else begin
      load_valid <= mem_re;
      if (mem_re) begin
        r_lane <= ea[1:0];
        r_half <= is_half;
        r_word <= is_word;
        r_uns  <= opcode[2];
      end
    end
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  assign sel_b = mem_rdata[8*r_lane +: 8];
  assign sel_h = r_lane[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  assign load_data = r_word ? mem_rdata :
                     r_half ? {{16{sel_h[15] & ~r_uns}}, sel_h} :
                              {{24{sel_b[7] & ~r_uns}}, sel_b};

  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (mem_we == 4'b0000 && !mem_re));

  assert_valid_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> load_valid);

  assert_no_valid_without_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !load_valid);

  assert_byte_store_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != 4'b0000 && opcode == OP_SB) |-> $onehot0(mem_we) && $countones(mem_we) == 1);

  assert_access_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we != 4'b0000) |-> (ea != 32'd0 && ea < LIMIT));

  assert_full_word_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we == 4'b1111) |-> (ea[1:0] == 2'b00));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!fault && !mem_re && mem_we == 4'b0000));

  always @(posedge clk)
    if (!rst_n) assert_reset_clear_R10: assert (!load_valid || $past(rst_n));
endmodule

// File: tb/tb_lsu_le.sv
module tb_lsu_le;
  localparam int unsigned MB = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  opcode = 6'h0;
  logic [31:0] base = 32'h0;
  logic [15:0] offset = 16'h0;
  logic [31:0] store_data = 32'h0;
  logic [7:0]  mem_addr;
  logic        mem_re;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 32'h0;
  logic        fault;
  logic        load_valid;
  logic [31:0] load_data;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  lsu_le #(.MEM_BYTES(MB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .base(base), .offset(offset), .store_data(store_data),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .fault(fault), .load_valid(load_valid), .load_data(load_data)
  );

  logic [31:0] ram [256];

  always @(posedge clk) begin
    for (int b = 0; b < 4; b++)
      if (mem_we[b]) ram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] b;
    logic [15:0] off;
    logic [31:0] sd;
    logic        f;
    logic        re;
    logic [3:0]  we;
    logic [7:0]  a;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{6'h2b, 32'h100, 16'h0000, 32'h8172F3A4, 1'b0, 1'b0, 4'b1111, 8'h40, 32'h8172F3A4},
    '{6'h28, 32'h100, 16'h0001, 32'h00000055, 1'b0, 1'b0, 4'b0010, 8'h40, 32'h55555555},
    '{6'h29, 32'h100, 16'h0002, 32'hAAAA1234, 1'b0, 1'b0, 4'b1100, 8'h40, 32'h12341234},
    '{6'h29, 32'h100, 16'h0000, 32'h0000BEEF, 1'b0, 1'b0, 4'b0011, 8'h40, 32'hBEEFBEEF},
    '{6'h28, 32'h200, 16'hFFFF, 32'h000000C3, 1'b0, 1'b0, 4'b1000, 8'h7F, 32'hC3C3C3C3},
    '{6'h29, 32'h201, 16'h0000, 32'h0, 1'b1, 1'b0, 4'b0000, 8'h80, 32'h0},
    '{6'h2b, 32'h102, 16'h0000, 32'h0, 1'b1, 1'b0, 4'b0000, 8'h40, 32'h0},
    '{6'h2b, 32'h3FC, 16'h0000, 32'h11223344, 1'b0, 1'b0, 4'b1111, 8'hFF, 32'h11223344},
    '{6'h2b, 32'h400, 16'h0000, 32'h0, 1'b1, 1'b0, 4'b0000, 8'h00, 32'h0},
    '{6'h28, 32'h000, 16'h0000, 32'h0, 1'b1, 1'b0, 4'b0000, 8'h00, 32'h0},
    '{6'h28, 32'h000, 16'h0001, 32'h0000007E, 1'b0, 1'b0, 4'b0010, 8'h00, 32'h7E7E7E7E},
    '{6'h28, 32'h3FF, 16'h0000, 32'h00000009, 1'b0, 1'b0, 4'b1000, 8'hFF, 32'h09090909},
    '{6'h23, 32'h102, 16'h0000, 32'h0, 1'b1, 1'b0, 4'b0000, 8'h40, 32'h0},
    '{6'h21, 32'h101, 16'h0000, 32'h0, 1'b1, 1'b0, 4'b0000, 8'h40, 32'h0},
    '{6'h23, 32'hFFFFFFFC, 16'h0004, 32'h0, 1'b1, 1'b0, 4'b0000, 8'h00, 32'h0},
    '{6'h24, 32'h3FF, 16'h0000, 32'h0, 1'b0, 1'b1, 4'b0000, 8'hFF, 32'h0},
    '{6'h09, 32'h100, 16'h0000, 32'h0, 1'b0, 1'b0, 4'b0000, 8'h40, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [31:0] b, input logic [15:0] off,
                       input logic [31:0] sd);
    @(negedge clk);
    req_valid = 1'b1; opcode = op; base = b; offset = off; store_data = sd;
    #1;
  endtask

  task automatic do_load(input logic [5:0] op, input logic [31:0] b, input logic [15:0] off,
                         input logic [31:0] exp, input string req);
    issue(op, b, off, 32'h0);
    @(posedge clk); #1;
    chk(load_valid && load_data == exp, req, load_data, exp);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!load_valid && !fault && mem_we == 4'b0 && !mem_re, "R10 reset", {31'b0, load_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].b, VEC[i].off, VEC[i].sd);
      chk(fault == VEC[i].f, "R6/R7/R9 fault", {31'b0, fault}, {31'b0, VEC[i].f});
      chk(mem_we == VEC[i].we && mem_re == VEC[i].re, "R4/R8/R9 strobes",
          {27'b0, mem_re, mem_we}, {27'b0, VEC[i].re, VEC[i].we});
      if (!VEC[i].f && (VEC[i].we != 4'b0 || VEC[i].re))
        chk(mem_addr == VEC[i].a, "R1 word address", {24'b0, mem_addr}, {24'b0, VEC[i].a});
      if (VEC[i].we != 4'b0)
        chk(mem_wdata == VEC[i].wd, "R5 store lanes", mem_wdata, VEC[i].wd);
      @(posedge clk); #1;
      chk(load_valid == VEC[i].re, "R2/R8 load_valid", {31'b0, load_valid}, {31'b0, VEC[i].re});
    end

    issue(6'h2b, 32'h100, 16'h0000, 32'h8172F3A4);
    do_load(6'h20, 32'h100, 16'h0000, 32'hFFFFFFA4, "R3 lb lane0");
    do_load(6'h24, 32'h101, 16'h0000, 32'h000000F3, "R3 lbu lane1");
    do_load(6'h20, 32'h101, 16'h0000, 32'hFFFFFFF3, "R3 lb lane1");
    do_load(6'h20, 32'h102, 16'h0000, 32'h00000072, "R3 lb lane2");
    do_load(6'h24, 32'h103, 16'h0000, 32'h00000081, "R3 lbu lane3");
    do_load(6'h21, 32'h100, 16'h0000, 32'hFFFFF3A4, "R3 lh low");
    do_load(6'h25, 32'h102, 16'h0000, 32'h00008172, "R3 lhu high");
    do_load(6'h21, 32'h102, 16'h0000, 32'hFFFF8172, "R3 lh high");
    do_load(6'h25, 32'h100, 16'h0000, 32'h0000F3A4, "R3 lhu low");
    do_load(6'h23, 32'h104, 16'hFFFC, 32'h8172F3A4, "R1 R2 lw negative offset");

    issue(6'h28, 32'h101, 16'h0000, 32'hFFFFFF55);
    do_load(6'h23, 32'h100, 16'h0000, 32'h817255A4, "R4 sb one lane");
    issue(6'h29, 32'h102, 16'h0000, 32'hFFFF1234);
    do_load(6'h23, 32'h100, 16'h0000, 32'h123455A4, "R4 sh upper half");
    issue(6'h2b, 32'h101, 16'h0003, 32'hDEADBEEF);
    issue(6'h29, 32'h103, 16'h0000, 32'h0000CAFE);
    chk(fault && mem_we == 4'b0, "R8 misaligned sh no write", {28'b0, mem_we}, 32'h0);
    do_load(6'h23, 32'h100, 16'h0000, 32'h123455A4, "R8 faulting store left word");
    do_load(6'h23, 32'h104, 16'h0000, 32'hDEADBEEF, "R1 offset sum store");

    issue(6'h23, 32'h100, 16'h0000, 32'h0);
    req_valid = 1'b0;
    #1;
    chk(!fault && !mem_re && mem_we == 4'b0, "R9 req_valid low", {31'b0, mem_re}, 32'h0);
    @(posedge clk); #1;
    chk(!load_valid, "R9 no load result", {31'b0, load_valid}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule